// File: doc/BRIEF.md
# Coulomb Counter Current Calculator

This block turns one reading of a battery charge counter into an average current in microamps. A reading is a signed charge count and the number of 15 ms samples it spans. With the reading come three trim bytes: a packed byte that holds a trim revision and a gain field, a signed offset byte, and a device version byte. On a start pulse the block latches all inputs. It then decides whether the trims may be trusted for this device version and revision. If they may, it removes the rate-scaled offset drift, then applies a fixed-step gain correction. Finally it converts the corrected count into microamps.

The three divisions in the calculation run one after another through a single radix-2 signed divider inside the block. Each division takes 64 cycles. A result appears with a one-cycle done pulse and stays on the outputs until the next result. A sample count of zero cannot be converted. In that case the block flags an error, reports zero current, and still pulses done.

Top module: `cc_current_calc`

## Requirements
- R1: After reset, busy, done and err are 0, trims_ok is 0 and current is 0.
- R2: The trim revision is trim_byte[3:0] and the gain field is trim_byte[7:4]. Trims are used (trims_ok=1) only when version is 0xC0 with revision exactly 3, or version is 0xC1 with revision 1 or more. In every other case gain and offset are both taken as 0 and trims_ok=0.
- R3: With trims used, the gain term is 1 minus the gain field. The offset-corrected count is multiplied by (10000 - gain*25) and divided by 10000, truncated toward zero.
- R4: With trims used, the offset byte is a signed 8-bit value. The term offset*samples*15/500, truncated toward zero, is subtracted from the count before the gain step.
- R5: current = corrected_count*366200/(samples*15), truncated toward zero, with all intermediate values held in 64-bit signed form.
- R6: When samples is 0, the result comes with err=1 and current=0, and done still pulses once.
- R7: start is accepted only while busy is 0. busy is 1 from the cycle after acceptance until the cycle done pulses. done lasts exactly one cycle, and done comes only after a busy period.
- R8: All data inputs are latched when start is accepted. A start pulse, or changed data, while busy has no effect on the result that is running.
- R9: current, err and trims_ok change only in the cycle done pulses and hold their values otherwise. A start accepted in the done cycle begins a new calculation, and the previous result stays on the outputs until that calculation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a calculation |
| acc_in | input | 32 | Signed charge count |
| samples_in | input | 24 | Number of 15 ms samples |
| trim_byte | input | 8 | Gain field [7:4], trim revision [3:0] |
| offset_trim | input | 8 | Signed offset trim, half counts per 250 ms |
| version | input | 8 | Device version code |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Sample count was zero |
| trims_ok | output | 1 | Trims were applied to this result |
| current | output | 64 | Signed average current in microamps |

## Verification
Two events can fall in the same cycle: a result finishing and a new start arriving. The bench provokes this in two ways. First, it raises start, with new data, in the very cycle done is seen. It then checks that the old result is still on the outputs partway through the new run, and that the second done carries the value expected for the new data. Second, it pulses start with different data while busy. It judges this by the first result staying correct and by no extra done or busy appearing after it.

// File: rtl/cc_current_calc.sv
module cc_current_calc #(
  parameter int ACC_W = 32,
  parameter int SMP_W = 24,
  parameter int W     = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ACC_W-1:0]    acc_in,
  input  logic [SMP_W-1:0]    samples_in,
  input  logic [7:0]          trim_byte,
  input  logic [7:0]          offset_trim,
  input  logic [7:0]          version,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                trims_ok,
  output logic signed [W-1:0] current
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic signed [W-1:0] K_SMPL   = W'(15);
  localparam logic signed [W-1:0] K_OFFDIV = W'(500);
  localparam logic signed [W-1:0] K_GDIV   = W'(10000);
  localparam logic signed [W-1:0] K_GSTEP  = W'(25);
  localparam logic signed [W-1:0] K_SCALE  = W'(366200);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DIV, S_FIN} state_t;
  state_t state;

  logic [1:0]          phase;
  logic                zero_r, ok_r, neg_r;
  logic [SMP_W-1:0]    n_r;
  logic signed [W-1:0] acc_r, gain_r, off_r;
  logic [W-1:0]        rem_r, quo_r, den_r;
  logic [CW-1:0]       cnt;

  wire [3:0] rev  = trim_byte[3:0];
  wire [3:0] gfld = trim_byte[7:4];
  wire valid_in = (version == 8'hC0 && rev == 4'd3) ||
                  (version == 8'hC1 && rev >= 4'd1);

  wire signed [W-1:0] n_s = $signed({{(W-SMP_W){1'b0}}, n_r});

  logic signed [W-1:0] num_ld;
  logic [W-1:0]        den_ld;
  always_comb begin
    case (phase)
      2'd0:    begin num_ld = off_r * n_s * K_SMPL;                 den_ld = K_OFFDIV; end
      2'd1:    begin num_ld = acc_r * (K_GDIV - gain_r * K_GSTEP);  den_ld = K_GDIV;   end
      default: begin num_ld = acc_r * K_SCALE;                      den_ld = n_s * K_SMPL; end
    endcase
  end

  wire [W-1:0] rem_sh = {rem_r[W-2:0], quo_r[W-1]};
  wire         fits   = rem_sh >= den_r;
  wire [W-1:0] rem_nx = fits ? rem_sh - den_r : rem_sh;
  wire [W-1:0] quo_nx = {quo_r[W-2:0], fits};
  wire signed [W-1:0] q_s = neg_r ? -$signed(quo_nx) : $signed(quo_nx);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= 2'd0;
      zero_r   <= 1'b0;
      ok_r     <= 1'b0;
      neg_r    <= 1'b0;
      n_r      <= '0;
      acc_r    <= '0;
      gain_r   <= '0;
      off_r    <= '0;
      rem_r    <= '0;
      quo_r    <= '0;
      den_r    <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      trims_ok <= 1'b0;
      current  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          acc_r  <= {{(W-ACC_W){acc_in[ACC_W-1]}}, acc_in};
          n_r    <= samples_in;
          ok_r   <= valid_in;
          gain_r <= valid_in ? W'(1) - $signed({{(W-4){1'b0}}, gfld}) : '0;
          off_r  <= valid_in ? {{(W-8){offset_trim[7]}}, offset_trim} : '0;
          zero_r <= (samples_in == '0);
          phase  <= 2'd0;
          state  <= (samples_in == '0) ? S_FIN : S_LOAD;
        end
        S_LOAD: begin
          neg_r <= num_ld[W-1];
          quo_r <= num_ld[W-1] ? W'(-num_ld) : W'(num_ld);
          rem_r <= '0;
          den_r <= den_ld;
          cnt   <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          rem_r <= rem_nx;
          quo_r <= quo_nx;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) begin
            case (phase)
              2'd0:    acc_r <= acc_r - q_s;
              default: acc_r <= q_s;
            endcase
            phase <= phase + 2'd1;
            state <= (phase == 2'd2) ? S_FIN : S_LOAD;
          end
        end
        S_FIN: begin
          done     <= 1'b1;
          err      <= zero_r;
          trims_ok <= ok_r;
          current  <= zero_r ? '0 : acc_r;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R7
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R7
  AST_ZERO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (current == '0)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(current) && $stable(err) && $stable(trims_ok))); // R9
endmodule

// File: tb/cc_current_calc_tb.sv
module cc_current_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] acc_in = '0;
  logic [23:0] samples_in = '0;
  logic [7:0]  trim_byte = '0;
  logic [7:0]  offset_trim = '0;
  logic [7:0]  version = '0;
  logic        busy, done, err, trims_ok;
  logic signed [63:0] current;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cc_current_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
    .samples_in(samples_in), .trim_byte(trim_byte), .offset_trim(offset_trim),
    .version(version), .busy(busy), .done(done), .err(err),
    .trims_ok(trims_ok), .current(current));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit trims_valid(input logic [7:0] tb, input logic [7:0] ver);
    return (ver == 8'hC0 && tb[3:0] == 4'd3) || (ver == 8'hC1 && tb[3:0] >= 4'd1);
  endfunction

  function automatic longint model(input int a, input int unsigned n,
                                   input logic [7:0] tb, input logic [7:0] ot,
                                   input logic [7:0] ver);
    longint g, o, x;
    if (n == 0) return 0;
    g = 0; o = 0;
    if (trims_valid(tb, ver)) begin
      g = 1 - longint'(tb[7:4]);
      o = longint'($signed(ot));
    end
    x = longint'(a) - (o * longint'(n) * 15) / 500;
    x = (x * (10000 - g * 25)) / 10000;
    return (x * 366200) / (longint'(n) * 15);
  endfunction

  task automatic drive(input int a, input int unsigned n, input logic [7:0] tb,
                       input logic [7:0] ot, input logic [7:0] ver);
    acc_in = a; samples_in = n[23:0]; trim_byte = tb; offset_trim = ot; version = ver;
  endtask

  task automatic wait_done(input string tag, output bit seen);
    seen = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    check(seen, {tag, " done timeout"}, 0, 1);
  endtask

  task automatic run_case(input string tag, input int a, input int unsigned n,
                          input logic [7:0] tb, input logic [7:0] ot, input logic [7:0] ver);
    longint exp;
    bit seen;
    exp = model(a, n, tb, ot, ver);
    @(negedge clk);
    drive(a, n, tb, ot, ver);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {tag, " busy after start R7"}, busy, 1);
    wait_done(tag, seen);
    if (seen) begin
      check(current == exp, {tag, " current"}, current, exp);
      check(err == (n == 0), {tag, " err"}, err, (n == 0));
      check(trims_ok == (n != 0 ? trims_valid(tb, ver) : trims_valid(tb, ver)),
            {tag, " trims_ok R2"}, trims_ok, trims_valid(tb, ver));
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, {tag, " done one cycle R7"}, done, 0);
    end
  endtask

  task automatic t_reset;
    check(busy == 0 && done == 0 && err == 0 && trims_ok == 0, "R1 flags after reset", busy, 0);
    check(current == 0, "R1 current after reset", current, 0);
  endtask

  task automatic t_validity;
    run_case("R2 untrusted version", 1000, 10, 8'h53, 8'h14, 8'hC2);
    run_case("R2 C0 rev3 accepted", 1000, 10, 8'h53, 8'h14, 8'hC0);
    run_case("R2 C0 rev2 rejected", 1000, 10, 8'h52, 8'h14, 8'hC0);
    run_case("R2 C0 rev4 rejected", 1000, 10, 8'h54, 8'h14, 8'hC0);
    run_case("R2 C1 rev0 rejected", 1000, 10, 8'h50, 8'h14, 8'hC1);
    run_case("R2 C1 rev1 accepted", 1000, 10, 8'h51, 8'h14, 8'hC1);
    run_case("R2 C1 rev15 accepted", 1000, 10, 8'hAF, 8'hEC, 8'hC1);
  endtask

  task automatic t_gain;
    run_case("R3 gain field 0", 40000, 3, 8'h03, 8'h00, 8'hC0);
    run_case("R3 gain field 15", 40000, 3, 8'hF3, 8'h00, 8'hC0);
    run_case("R3 gain negative count", -123457, 7, 8'h93, 8'h00, 8'hC0);
  endtask

  task automatic t_offset;
    run_case("R4 positive offset", 5000, 1000, 8'h13, 8'h7F, 8'hC0);
    run_case("R4 negative offset", 5000, 1000, 8'h13, 8'h80, 8'hC0);
    run_case("R4 offset truncation", -3, 17, 8'h21, 8'h05, 8'hC1);
  endtask

  task automatic t_scale;
    run_case("R5 max count one sample", 32'h7FFF_FFFF, 1, 8'hF3, 8'h80, 8'hC0);
    run_case("R5 min count many samples", 32'h8000_0000, 24'hFF_FFFF, 8'h03, 8'h7F, 8'hC0);
    run_case("R5 small negative", -1, 4, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_zero;
    run_case("R6 zero samples", 9999, 0, 8'h53, 8'h14, 8'hC0);
  endtask

  task automatic t_busy_ignore;
    longint exp;
    bit seen;
    exp = model(777777, 33, 8'h43, 8'hF0, 8'hC0);
    @(negedge clk);
    drive(777777, 33, 8'h43, 8'hF0, 8'hC0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    drive(-5, 0, 8'h00, 8'h00, 8'h00);
    start = 1'b1;
    repeat (10) @(negedge clk);
    start = 1'b0;
    wait_done("R8 start while busy", seen);
    if (seen) begin
      check(current == exp, "R8 result unaffected", current, exp);
      check(err == 0, "R8 err unaffected", err, 0);
    end
    seen = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (done || busy) seen = 1;
    end
    check(!seen, "R7 no extra run after ignored start", seen, 0);
  endtask

  task automatic t_back_to_back;
    longint e1, e2;
    bit seen;
    e1 = model(123456, 50, 8'h73, 8'h22, 8'hC0);
    e2 = model(-654321, 9, 8'hC5, 8'hE0, 8'hC1);
    @(negedge clk);
    drive(123456, 50, 8'h73, 8'h22, 8'hC0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R9 first", seen);
    check(current == e1, "R9 first current", current, e1);
    drive(-654321, 9, 8'hC5, 8'hE0, 8'hC1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 start in done cycle accepted", busy, 1);
    repeat (40) @(negedge clk);
    check(current == e1 && trims_ok == 1'b1, "R9 previous result held", current, e1);
    wait_done("R9 second", seen);
    check(current == e2, "R9 second current", current, e2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_validity();
    t_gain();
    t_offset();
    t_scale();
    t_zero();
    t_busy_ignore();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule